// File: doc/BRIEF.md
# SCSI Receive Parity Checker with Attention Control

This block watches every byte received from a parallel SCSI data bus and tests the eight data lines together with the parity line for odd parity. It works the same way whether the interface is acting as initiator or as target. One strobe per byte marks the moment the byte is valid. In initiator role this is the cycle the request is seen. In target role it is the cycle the acknowledge is seen. A bad byte raises a sticky error flag, and that flag can be forwarded as an interrupt through an enable bit.

In initiator role the block can also raise the attention line automatically when a byte arrives with bad parity. It does this on the same byte, one clock before the handshake logic may release acknowledge, and it does not stop the transfer. Attention then stays up until the phase sequencer reports a bus phase change, or until software clears the flag. The same attention output serves the selection phase. When a control bit asks for it, attention follows the selection-active signal, and it drops in the very cycle a selection timeout is signalled.

Top module: `scsi_par_atn`

## Requirements
- R1: A byte whose eight data bits plus parity bit hold an even number of ones is a parity error. When checking is enabled and `byte_stb` is high, such a byte sets `par_err_flag` on the clock edge that samples the strobe. A bad byte with `byte_stb` low has no effect.
- R2: With `chk_en` low, no byte sets `par_err_flag` or raises attention, whatever its parity.
- R3: `par_err_flag` stays set until a cycle with `flag_clr` high, which clears it on the next edge. If a new error and `flag_clr` arrive in the same cycle, the flag stays set.
- R4: `irq` equals `par_err_flag` AND `irq_en`, combinationally.
- R5: Automatic attention on a parity error is raised only when `chk_en` and `auto_atn_en` are both high and `tgt_role` is 0 (initiator).
- R6: With `tgt_role` = 1 (target), a parity error never raises attention, but it still sets the flag.
- R7: Once raised for a parity error, `atn` stays high through further bytes, good or bad, until `phase_chg` or `flag_clr` is seen. `phase_chg` leaves the flag untouched.
- R8: `ack_rel_ok` is high for exactly the one cycle after a strobed byte. In that cycle the parity verdict, and any automatic attention for that byte, are already visible.
- R9: With `sel_atn_en` high, `atn` follows `sel_active` in the same cycle. It is forced low in any cycle where `sel_timeout` is high. With `sel_atn_en` low, selection does not drive attention.
- R10: After reset, `atn`, `par_err_flag`, `irq` and `ack_rel_ok` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_data | input | DW | Received data bus byte |
| bus_par | input | 1 | Received parity line |
| byte_stb | input | 1 | Byte valid: request seen (initiator) or acknowledge seen (target) |
| chk_en | input | 1 | Enable parity checking |
| auto_atn_en | input | 1 | Enable automatic attention on parity error |
| irq_en | input | 1 | Forward error flag to interrupt |
| tgt_role | input | 1 | 0 = initiator, 1 = target |
| sel_atn_en | input | 1 | Drive attention during selection |
| sel_active | input | 1 | Selection in progress |
| sel_timeout | input | 1 | Selection timeout pulse |
| phase_chg | input | 1 | Bus phase change seen |
| flag_clr | input | 1 | Software write-one-to-clear of the error flag |
| atn | output | 1 | Attention line request |
| par_err_flag | output | 1 | Sticky parity error status |
| irq | output | 1 | Interrupt request |
| ack_rel_ok | output | 1 | Verdict ready; acknowledge may be released |

## Verification
The error flag, the parity-driven attention and `ack_rel_ok` are registered, so each is due one clock after the edge that samples the strobe or clear. The bench drives inputs on the falling edge and reads these results at the next falling edge. Selection attention and `irq` are combinational, so they are read a short delay after the inputs change, within the same cycle. `ack_rel_ok` is checked again one cycle later to confirm that it lasts a single cycle.

// File: rtl/scsi_par_pkg.sv
package scsi_par_pkg;

  localparam int BUS_W   = 8;
  localparam int MAX_W   = 32;

  typedef enum logic {
    ROLE_INIT = 1'b0,
    ROLE_TGT  = 1'b1
  } role_e;

  // True when the supplied bits (data plus parity, zero padded) carry odd ones.
  function automatic logic odd_ones(input logic [MAX_W:0] bits);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i <= MAX_W; i++) acc = acc ^ bits[i];
    return acc;
  endfunction

endpackage

// File: rtl/scsi_par_chk.sv
module scsi_par_chk
  import scsi_par_pkg::*;
#(
  parameter int DW = BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] data_i,
  input  logic          par_i,
  input  logic          stb_i,
  input  logic          chk_en_i,
  output logic          err_evt_o,
  output logic          verdict_vld_o
);

  localparam int PAD = MAX_W + 1 - (DW + 1);

  logic          bad_byte;
  logic [MAX_W:0] padded;

  assign padded    = {{PAD{1'b0}}, par_i, data_i};
  assign bad_byte  = ~odd_ones(padded);
  assign err_evt_o = stb_i & chk_en_i & bad_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) verdict_vld_o <= 1'b0;
    else        verdict_vld_o <= stb_i;
  end

  a_r2_no_report_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt_o |-> chk_en_i);

  a_r1_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt_o |-> stb_i);

endmodule

// File: rtl/scsi_err_flag.sv
module scsi_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic err_evt_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_o <= 1'b0;
    else if (err_evt_i) flag_o <= 1'b1;
    else if (clr_i)     flag_o <= 1'b0;
  end

  assign irq_o = flag_o & irq_en_i;

  a_r1_flag_follows_err: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt_i |=> flag_o);

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);

  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !err_evt_i) |=> !flag_o);

endmodule

// File: rtl/scsi_atn_ctl.sv
module scsi_atn_ctl
  import scsi_par_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic err_evt_i,
  input  logic auto_en_i,
  input  role_e role_i,
  input  logic phase_chg_i,
  input  logic clr_i,
  input  logic sel_atn_en_i,
  input  logic sel_active_i,
  input  logic sel_timeout_i,
  output logic atn_par_o,
  output logic atn_sel_o,
  output logic atn_o
);

  logic arm;

  assign arm = err_evt_i & auto_en_i & (role_i == ROLE_INIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    atn_par_o <= 1'b0;
    else if (arm)                  atn_par_o <= 1'b1;
    else if (phase_chg_i || clr_i) atn_par_o <= 1'b0;
  end

  assign atn_sel_o = sel_atn_en_i & sel_active_i & ~sel_timeout_i;
  assign atn_o     = atn_par_o | atn_sel_o;

  a_r5_rise_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(atn_par_o) |-> $past(auto_en_i && err_evt_i));

  a_r6_rise_needs_initiator: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(atn_par_o) |-> $past(role_i == ROLE_INIT));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (atn_par_o && !phase_chg_i && !clr_i) |=> atn_par_o);

  a_r9_timeout_drops: assert property (@(posedge clk) disable iff (!rst_n)
    sel_timeout_i |-> !atn_sel_o);

endmodule

// File: rtl/scsi_par_atn.sv
module scsi_par_atn
  import scsi_par_pkg::*;
#(
  parameter int DW = BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_par,
  input  logic          byte_stb,
  input  logic          chk_en,
  input  logic          auto_atn_en,
  input  logic          irq_en,
  input  logic          tgt_role,
  input  logic          sel_atn_en,
  input  logic          sel_active,
  input  logic          sel_timeout,
  input  logic          phase_chg,
  input  logic          flag_clr,
  output logic          atn,
  output logic          par_err_flag,
  output logic          irq,
  output logic          ack_rel_ok
);

  logic  err_evt;
  logic  atn_par;
  logic  atn_sel;
  role_e role;

  assign role = role_e'(tgt_role);

  scsi_par_chk #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .data_i        (bus_data),
    .par_i         (bus_par),
    .stb_i         (byte_stb),
    .chk_en_i      (chk_en),
    .err_evt_o     (err_evt),
    .verdict_vld_o (ack_rel_ok)
  );

  scsi_err_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_evt_i (err_evt),
    .clr_i     (flag_clr),
    .irq_en_i  (irq_en),
    .flag_o    (par_err_flag),
    .irq_o     (irq)
  );

  scsi_atn_ctl u_atn (
    .clk           (clk),
    .rst_n         (rst_n),
    .err_evt_i     (err_evt),
    .auto_en_i     (auto_atn_en),
    .role_i        (role),
    .phase_chg_i   (phase_chg),
    .clr_i         (flag_clr),
    .sel_atn_en_i  (sel_atn_en),
    .sel_active_i  (sel_active),
    .sel_timeout_i (sel_timeout),
    .atn_par_o     (atn_par),
    .atn_sel_o     (atn_sel),
    .atn_o         (atn)
  );

  a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> par_err_flag);

  a_r8_atn_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rel_ok && $past(err_evt && auto_atn_en && !tgt_role)) |-> atn);

  a_r8_flag_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rel_ok && $past(err_evt)) |-> par_err_flag);

endmodule

// File: tb/test_scsi_par_atn.sv
module test_scsi_par_atn;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_data = '0;
  logic       bus_par = 1'b0, byte_stb = 1'b0, chk_en = 1'b0, auto_atn_en = 1'b0;
  logic       irq_en = 1'b0, tgt_role = 1'b0, sel_atn_en = 1'b0, sel_active = 1'b0;
  logic       sel_timeout = 1'b0, phase_chg = 1'b0, flag_clr = 1'b0;
  logic       atn, par_err_flag, irq, ack_rel_ok;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  scsi_par_atn i_scsi_par_atn (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_par(bus_par),
    .byte_stb(byte_stb), .chk_en(chk_en), .auto_atn_en(auto_atn_en),
    .irq_en(irq_en), .tgt_role(tgt_role), .sel_atn_en(sel_atn_en),
    .sel_active(sel_active), .sel_timeout(sel_timeout), .phase_chg(phase_chg),
    .flag_clr(flag_clr), .atn(atn), .par_err_flag(par_err_flag), .irq(irq),
    .ack_rel_ok(ack_rel_ok)
  );

  // {data[13:6], par[5], chk[4], auto[3], tgt[2], exp_flag[1], exp_atn[0]}
  localparam logic [13:0] VEC [9] = '{
    {8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'h01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'hA5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h3C, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h7E, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h80, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'hFE, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input logic p);
    @(negedge clk);
    bus_data = d; bus_par = p; byte_stb = 1'b1;
    @(negedge clk);
    byte_stb = 1'b0;
  endtask

  task automatic clear_all();
    @(negedge clk);
    flag_clr = 1'b1; phase_chg = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0; phase_chg = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 atn", atn, 1'b0);
    check("R10 flag", par_err_flag, 1'b0);
    check("R10 irq", irq, 1'b0);
    check("R10 ack_rel_ok", ack_rel_ok, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1 R2 R5 R6 R8
    foreach (VEC[i]) begin
      clear_all();
      check("R3 cleared", par_err_flag, 1'b0);
      chk_en = VEC[i][4]; auto_atn_en = VEC[i][3]; tgt_role = VEC[i][2];
      send_byte(VEC[i][13:6], VEC[i][5]);
      check("R8 ack_rel_ok", ack_rel_ok, 1'b1);
      check("R1/R2 flag", par_err_flag, VEC[i][1]);
      check("R5/R6 atn", atn, VEC[i][0]);
      @(negedge clk);
      check("R8 one cycle", ack_rel_ok, 1'b0);
    end

    // R1: bad byte without strobe has no effect
    clear_all();
    chk_en = 1'b1; auto_atn_en = 1'b1; tgt_role = 1'b0;
    bus_data = 8'h00; bus_par = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R1 no strobe flag", par_err_flag, 1'b0);
    check("R1 no strobe atn", atn, 1'b0);

    // R7 / R3: hold through further bytes, phase change drops atn only
    send_byte(8'h00, 1'b0);
    send_byte(8'h01, 1'b0);
    send_byte(8'h03, 1'b1);
    check("R7 atn held", atn, 1'b1);
    check("R3 flag sticky", par_err_flag, 1'b1);
    // R4
    irq_en = 1'b0; #1;
    check("R4 irq masked", irq, 1'b0);
    irq_en = 1'b1; #1;
    check("R4 irq on", irq, 1'b1);
    @(negedge clk);
    phase_chg = 1'b1;
    @(negedge clk);
    phase_chg = 1'b0;
    check("R7 phase drops atn", atn, 1'b0);
    check("R7 phase keeps flag", par_err_flag, 1'b1);

    // R3: set wins over clear in same cycle, then clear alone
    @(negedge clk);
    bus_data = 8'h00; bus_par = 1'b0; byte_stb = 1'b1; flag_clr = 1'b1;
    @(negedge clk);
    byte_stb = 1'b0; flag_clr = 1'b0;
    check("R3 set wins", par_err_flag, 1'b1);
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    check("R3 clear", par_err_flag, 1'b0);
    check("R7 clear drops atn", atn, 1'b0);
    check("R4 irq follows", irq, 1'b0);

    // R9: selection attention
    sel_atn_en = 1'b1; sel_active = 1'b1; #1;
    check("R9 sel atn", atn, 1'b1);
    sel_timeout = 1'b1; #1;
    check("R9 timeout same cycle", atn, 1'b0);
    @(negedge clk);
    sel_timeout = 1'b0; sel_active = 1'b0; #1;
    check("R9 sel ended", atn, 1'b0);
    sel_atn_en = 1'b0; sel_active = 1'b1; #1;
    check("R9 disabled", atn, 1'b0);
    sel_active = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule